// File: doc/BRIEF.md
# Soft-Start Reference Ramp Generator

This block produces the digital reference code that a switching regulator's feedback comparator uses during start-up. A start pulse clears the code to zero. The code then climbs by a fixed step on each slow tick until it reaches the regulation setpoint. The code is clamped at that setpoint and held there, and a done flag is raised at the same time.

The slow tick comes from the system clock through a parameterised prescaler. The prescaler counts only the clock cycles on which the tick-enable input is high. With the default settings, the 9-bit code has one LSB per ramp step of about 1.8 mV, and the setpoint is 417 (about 750 mV). At a tick rate near 500 kHz, the full ramp takes about 0.85 ms.

While the ramp runs, an active flag is high. The switching logic uses this flag to turn on zero-current detection on the low-side switch, so that a pre-biased output is never discharged. A fault-clear input overrides everything else. It returns the block to idle with the code at zero, and the block stays there until the next start pulse.

Top module: `ss_ref_ramp`

## Requirements
- R1: While reset is asserted and after its release, `ref_code_o` is 0 and both `ss_active_o` and `ss_done_o` are 0.
- R2: A start pulse without fault-clear restarts the ramp from any state: on the next clock `ref_code_o` is 0, `ss_active_o` is 1 and `ss_done_o` is 0.
- R3: During the ramp the prescaler counts only cycles with `tick_en_i` high. Each run of `TICK_DIV` counted cycles, measured from the start or from the previous tick, is one tick, and the code changes only on the clock after a tick.
- R4: `ref_code_o` never exceeds `FINAL_CODE` (default 417). A step that would pass the setpoint lands exactly on it.
- R5: On the clock where the code reaches `FINAL_CODE`, `ss_active_o` falls and `ss_done_o` rises. Afterwards the code holds at the setpoint and further ticks are ignored. With `tick_en_i` held high, done arrives `FINAL_CODE/STEP_CODE × TICK_DIV` clocks after the start edge.
- R6: `ss_active_o` and `ss_done_o` are never high together. Active implies the code is below the setpoint, and done implies the code equals it.
- R7: Fault-clear has priority over start. On the next clock the code is 0 and both flags are 0, and the block stays idle until a later start pulse.
- R8: During the ramp the code never decreases, and each change is at most `STEP_CODE` (default 1).
- R9: In idle (after reset or fault-clear), `tick_en_i` activity leaves the code at 0 and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| start_i | input | 1 | One-cycle pulse that starts a new ramp from zero |
| fault_i | input | 1 | Fault-clear: returns to idle with zero code, overrides start |
| tick_en_i | input | 1 | Qualifies the clock cycles the prescaler counts |
| ref_code_o | output | CODE_W | Reference code for the feedback DAC |
| ss_active_o | output | 1 | High while the ramp is in progress |
| ss_done_o | output | 1 | High while the setpoint is held after a complete ramp |

## Verification
The assertions check on every cycle the flag exclusivity and flag/code consistency, the setpoint clamp, the bounded and monotonic step, the fact that a tick only happens on an enabled cycle during the ramp, the frozen code between ticks and in hold, and the one-clock response to start and fault-clear. Some behaviour only the bench scenarios can show. That includes the exact number of clocks from start to done, the correct count of enabled cycles between ticks under irregular enable patterns, the restart from mid-ramp and from hold, and the return to idle after fault-clear. The bench shows these by comparing against its own cycle model.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_RAMP = 2'd1,
    SS_HOLD = 2'd2
  } ss_state_e;

  // number of ticks a full ramp needs (ceiling division)
  function automatic int unsigned ramp_ticks(input int unsigned final_code,
                                             input int unsigned step);
    return (final_code + step - 1) / step;
  endfunction

endpackage

// File: rtl/ssr_prescaler.sv
module ssr_prescaler #(
  parameter int unsigned TICK_DIV = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_w;

  assign wrap_w = (cnt_q == LAST);
  assign tick_o = run_i & en_i & wrap_w & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || !run_i) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= wrap_w ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ssr_ramp_core.sv
module ssr_ramp_core #(
  parameter int unsigned CODE_W     = 9,
  parameter int unsigned FINAL_CODE = 417,
  parameter int unsigned STEP_CODE  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  output logic [CODE_W-1:0] code_o,
  output logic              last_step_o
);
  localparam logic [CODE_W-1:0] FINAL_V = CODE_W'(FINAL_CODE);
  localparam logic [CODE_W:0]   STEP_W  = (CODE_W+1)'(STEP_CODE);
  localparam logic [CODE_W:0]   FINAL_W = (CODE_W+1)'(FINAL_CODE);

  // saturating step toward the setpoint
  function automatic logic [CODE_W-1:0] sat_next(input logic [CODE_W-1:0] c);
    logic [CODE_W:0] sum;
    sum = {1'b0, c} + STEP_W;
    if (sum >= FINAL_W) return FINAL_V;
    return sum[CODE_W-1:0];
  endfunction

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] next_w;

  assign next_w      = sat_next(code_q);
  assign last_step_o = adv_i & ~clear_i & (next_w == FINAL_V);
  assign code_o      = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
    end else if (clear_i) begin
      code_q <= '0;
    end else if (adv_i) begin
      code_q <= next_w;
    end
  end

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
  import ssr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fault_i,
  input  logic last_step_i,
  output logic clr_o,
  output logic run_o,
  output logic active_o,
  output logic done_o
);
  ss_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (fault_i) begin
      state_d = SS_IDLE;
    end else if (start_i) begin
      state_d = SS_RAMP;
    end else if (state_q == SS_RAMP && last_step_i) begin
      state_d = SS_HOLD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SS_IDLE;
    else         state_q <= state_d;
  end

  assign clr_o    = start_i | fault_i;
  assign run_o    = (state_q == SS_RAMP);
  assign active_o = (state_q == SS_RAMP);
  assign done_o   = (state_q == SS_HOLD);

endmodule

// File: rtl/ss_ref_ramp.sv
module ss_ref_ramp
  import ssr_pkg::*;
#(
  parameter int unsigned CODE_W     = 9,
  parameter int unsigned FINAL_CODE = 417,
  parameter int unsigned STEP_CODE  = 1,
  parameter int unsigned TICK_DIV   = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fault_i,
  input  logic              tick_en_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              ss_active_o,
  output logic              ss_done_o
);
  localparam int unsigned NUM_TICKS = ramp_ticks(FINAL_CODE, STEP_CODE);

  // internal events, named for the checker
  logic tick_w;
  logic last_step_w;
  logic clr_w;
  logic run_w;

  ssr_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .fault_i     (fault_i),
    .last_step_i (last_step_w),
    .clr_o       (clr_w),
    .run_o       (run_w),
    .active_o    (ss_active_o),
    .done_o      (ss_done_o)
  );

  ssr_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_w),
    .run_i  (run_w),
    .en_i   (tick_en_i),
    .tick_o (tick_w)
  );

  ssr_ramp_core #(
    .CODE_W     (CODE_W),
    .FINAL_CODE (FINAL_CODE),
    .STEP_CODE  (STEP_CODE)
  ) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clr_w),
    .adv_i       (tick_w),
    .code_o      (ref_code_o),
    .last_step_o (last_step_w)
  );

  if (NUM_TICKS == 0 || FINAL_CODE >= (1 << CODE_W)) begin : g_bad_cfg
    initial $display("ss_ref_ramp: setpoint does not fit CODE_W or is zero");
  end

endmodule

// File: rtl/ss_ref_ramp_chk.sv
module ss_ref_ramp_chk #(
  parameter int unsigned CODE_W     = 9,
  parameter int unsigned FINAL_CODE = 417,
  parameter int unsigned STEP_CODE  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              fault_i,
  input logic              tick_en_i,
  input logic [CODE_W-1:0] ref_code_o,
  input logic              ss_active_o,
  input logic              ss_done_o,
  input logic              tick_w,
  input logic              last_step_w
);
  localparam logic [CODE_W-1:0] FINAL_V = CODE_W'(FINAL_CODE);
  localparam logic [CODE_W-1:0] STEP_V  = CODE_W'(STEP_CODE);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !fault_i) |=> (ref_code_o == '0 && ss_active_o && !ss_done_o));

  p_tick_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_w |-> (tick_en_i && ss_active_o));

  p_no_tick_still_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_active_o && !tick_w && !start_i && !fault_i) |=> $stable(ref_code_o));

  p_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_code_o <= FINAL_V);

  p_handoff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_step_w |=> (ss_done_o && !ss_active_o && ref_code_o == FINAL_V));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_done_o && !start_i && !fault_i) |=> (ss_done_o && $stable(ref_code_o)));

  p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ss_active_o && ss_done_o));

  p_done_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_done_o |-> (ref_code_o == FINAL_V));

  p_active_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_active_o |-> (ref_code_o < FINAL_V));

  p_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (ref_code_o == '0 && !ss_active_o && !ss_done_o));

  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_active_o && tick_w) |=>
      (ref_code_o > $past(ref_code_o) && (ref_code_o - $past(ref_code_o)) <= STEP_V));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_active_o && !ss_done_o && !start_i) |=>
      (ref_code_o == '0 && !ss_active_o && !ss_done_o));

endmodule

bind ss_ref_ramp ss_ref_ramp_chk #(
  .CODE_W     (CODE_W),
  .FINAL_CODE (FINAL_CODE),
  .STEP_CODE  (STEP_CODE)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .fault_i     (fault_i),
  .tick_en_i   (tick_en_i),
  .ref_code_o  (ref_code_o),
  .ss_active_o (ss_active_o),
  .ss_done_o   (ss_done_o),
  .tick_w      (tick_w),
  .last_step_w (last_step_w)
);

// File: tb/ss_ref_ramp_tb_top.sv
module ss_ref_ramp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 9;
  localparam int FINAL      = 417;
  localparam int STEP       = 1;
  localparam int DIV        = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              fault = 1'b0;
  logic              ten = 1'b0;
  logic [CODE_W-1:0] code;
  logic              act;
  logic              dn;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model: 0 idle, 1 ramping, 2 holding
  int m_st = 0;
  int m_code = 0;
  int m_cnt = 0;
  int max_seen = 0;
  int max_delta = 0;
  int min_delta = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ss_ref_ramp #(
    .CODE_W(CODE_W), .FINAL_CODE(FINAL), .STEP_CODE(STEP), .TICK_DIV(DIV)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fault_i(fault),
    .tick_en_i(ten), .ref_code_o(code), .ss_active_o(act), .ss_done_o(dn)
  );

  function automatic int step_to(input int c);
    return (c + STEP > FINAL) ? FINAL : c + STEP;
  endfunction

  task automatic chk(input string req, input int actual, input int expected);
    n_cmp++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic model_edge(input bit s, input bit f, input bit e);
    if (f) begin
      m_st = 0; m_code = 0; m_cnt = 0;
    end else if (s) begin
      m_st = 1; m_code = 0; m_cnt = 0;
    end else if (m_st == 1 && e) begin
      if (m_cnt == DIV - 1) begin
        m_cnt = 0;
        m_code = step_to(m_code);
        if (m_code == FINAL) m_st = 2;
      end else begin
        m_cnt++;
      end
    end
  endtask

  task automatic cyc(input bit s, input bit f, input bit e, input string req);
    int prev;
    @(negedge clk);
    start = s; fault = f; ten = e;
    prev = int'(code);
    @(posedge clk);
    model_edge(s, f, e);
    #(CLK_PERIOD/4);
    if (int'(code) > max_seen) max_seen = int'(code);
    if (act && !s && !f) begin
      if (int'(code) - prev > max_delta) max_delta = int'(code) - prev;
      if (int'(code) - prev < min_delta) min_delta = int'(code) - prev;
    end
    chk({req, " code"}, int'(code), m_code);
    chk({req, " active R6"}, int'(act), int'(m_st == 1));
    chk({req, " done R6"}, int'(dn), int'(m_st == 2));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int n;
    void'($urandom(32'd1234));
    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    chk("R1 in reset code", int'(code), 0);
    chk("R1 in reset flags", int'({act, dn}), 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, "R1");

    // R9: idle ignores tick enable
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, "R9 idle");
    chk("R9 idle code", int'(code), 0);

    // R3/R5: full ramp with enable held, exact duration
    cyc(1, 0, 1, "R2 start");
    n = 0;
    while (!dn && n < 5000) begin cyc(0, 0, 1, "R3 ramp"); n++; end
    chk("R5 ramp clocks", n, ((FINAL + STEP - 1) / STEP) * DIV);
    chk("R5 final code", int'(code), FINAL);
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, "R5 hold");
    chk("R5 hold code", int'(code), FINAL);

    // R2: restart from hold
    cyc(1, 0, 1, "R2 restart");
    chk("R2 code after start", int'(code), 0);
    chk("R2 active after start", int'(act), 1);

    // R3/R8: random enable ramp to done
    n = 0;
    while (!dn && n < 8000) begin
      cyc(0, 0, ($urandom % 100) < 60, "R3 rand-en"); n++;
    end
    chk("R5 done after random ramp", int'(dn), 1);

    // R3: enable low stalls the ramp
    cyc(1, 0, 1, "R2 start");
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, "R3 run");
    for (int i = 0; i < 15; i++) cyc(0, 0, 0, "R3 stall");
    chk("R3 stalled code", int'(code), 10 / DIV);

    // R2: mid-ramp restart
    for (int i = 0; i < 100; i++) cyc(0, 0, 1, "R3 run");
    cyc(1, 0, 1, "R2 mid restart");
    chk("R2 mid restart code", int'(code), 0);

    // R7: fault mid-ramp, then fault with start, then stay idle
    for (int i = 0; i < 60; i++) cyc(0, 0, 1, "R3 run");
    cyc(0, 1, 1, "R7 fault");
    chk("R7 fault code", int'(code), 0);
    chk("R7 fault flags", int'({act, dn}), 0);
    cyc(1, 0, 1, "R2 start");
    for (int i = 0; i < 30; i++) cyc(0, 0, 1, "R3 run");
    cyc(1, 1, 1, "R7 fault over start");
    chk("R7 priority flags", int'({act, dn}), 0);
    for (int i = 0; i < 25; i++) cyc(0, 0, 1, "R7 stays idle");
    chk("R7 idle code", int'(code), 0);

    // fault from hold
    cyc(1, 0, 1, "R2 start");
    n = 0;
    while (!dn && n < 5000) begin cyc(0, 0, 1, "R3 ramp"); n++; end
    cyc(0, 1, 0, "R7 fault from hold");
    chk("R7 hold cleared", int'(code), 0);

    // mixed random traffic
    for (int i = 0; i < 6000; i++) begin
      cyc(($urandom % 400) == 0, ($urandom % 900) == 0, ($urandom % 100) < 50, "R3 mixed");
    end

    chk("R4 max code seen", max_seen, FINAL);
    chk("R8 max step", max_delta, STEP);
    chk("R8 no decrease", min_delta, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule